// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single channel of an interval timer. A host control block writes a mode word (six output behaviours, binary or four-digit decimal counting) and then an initial count. The channel runs a down counter that steps once per count clock. The count clock is the block clock `clk`. The channel drives a single `out` waveform whose shape depends on the mode. The mode word also sets how the `gate` input works: as a level that pauses counting, or as a rising-edge trigger that starts or restarts a count.

The six modes are:
- Mode 0: an interrupt on terminal count.
- Mode 1: a retriggerable one-shot.
- Mode 2: a divide-by-N rate generator.
- Mode 3: a square wave.
- Mode 4: a strobe started by software.
- Mode 5: a strobe started by hardware.

A latch command takes a snapshot of the live count. The host reads that snapshot until it signals that the read is done. Counting goes on while the snapshot is held.

Top module: `pit_chan`

## Requirements
- R1: While and after reset, `out` is 1, `rdHeld` is 0 and `rdData` reads 0.
- R2: After a mode write the channel does nothing until a count is written. In modes 1 and 5 it also waits for a rising edge on `gate`. Until then `out` stays at its post-mode-write level and the count does not change.
- R3: A written count of 0 is taken as the largest count: 10000 in decimal mode, 2^16 in binary mode.
- R4: Mode 0 (code 0):
  - `out` falls at the clock edge that takes the count write, and the count loads on the following edge.
  - `out` rises on the edge that steps the count from 1 to 0, which is N+1 edges after the write.
  - After that the count holds at 0 and `out` stays high until the next count or mode write.
- R5: In modes 0, 2, 3 and 4, a low `gate` freezes the count. Counting resumes from the frozen value once `gate` is high again.
- R6: Mode 1 (code 1):
  - A `gate` rising edge loads the count and drives `out` low from the next cycle, for N cycles.
  - A further rising edge reloads the count and restarts the pulse.
  - A count written during a pulse does not change that pulse. It takes effect at the next trigger.
- R7: Mode 2 (code 2):
  - The period is N cycles, with `out` low for exactly one cycle while the count is 1.
  - A low `gate` forces `out` high and pauses the count.
  - A `gate` rising edge reloads the count.
- R8: Mode 3 (code 3): `out` is high for ceil(N/2) cycles and low for floor(N/2) cycles (N ≥ 2). The `gate` handling is the same as in mode 2.
- R9: Mode 4 (code 4): `out` goes low for exactly one cycle, N+1 edges after the count write. It does this once per write.
- R10: Mode 5 (code 5):
  - A `gate` rising edge loads the count, and `out` goes low for one cycle N edges later.
  - A new rising edge before that point restarts the count.
- R11: With `cfgBcd` = 1 the count steps as four packed decimal digits, four bits per digit with the least significant digit in bits 3:0. For example, 0100 steps to 0099.
- R12: A `latchCmd` pulse copies the count into a snapshot, and `rdHeld` rises. `rdData` returns the snapshot until `rdDone`, while counting continues. Otherwise `rdData` shows the live count.
- R13: Mode codes 6 and 7 behave as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the count clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWr | input | 1 | Mode write strobe; takes priority over `cntWr` |
| cfgMode | input | 3 | Mode code 0..7 |
| cfgBcd | input | 1 | 1 selects decimal counting |
| cntWr | input | 1 | Count write strobe |
| cntVal | input | 16 | Initial count |
| gate | input | 1 | Level enable or trigger, depending on the mode |
| latchCmd | input | 1 | Snapshot request |
| rdDone | input | 1 | Releases the snapshot |
| out | output | 1 | Channel output waveform |
| rdData | output | 16 | Snapshot while held, live count otherwise |
| rdHeld | output | 1 | A snapshot is being held |

## Verification
Each result has a fixed edge at which it is due:
- A count write lowers `out` in mode 0 at the same edge and loads the counter one edge later. The terminal count of a count N then lands N+1 edges after the write.
- A `gate` rising edge in modes 1 and 5 loads the counter at the edge that first samples `gate` high.
- A latch or a release shows on `rdData` one edge after the strobe.

The bench drives every input just after a falling edge. It counts rising edges from that stimulus to the edge where the result is due and samples at the falling edge that follows. It checks one edge early and at the due edge, so an off-by-one in either direction shows up. Periodic modes are measured as run lengths of `out` after the first falling transition, so the partial first period is never judged.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;

  localparam logic [2:0] MODE_TC      = 3'd0;
  localparam logic [2:0] MODE_ONESHOT = 3'd1;
  localparam logic [2:0] MODE_RATE    = 3'd2;
  localparam logic [2:0] MODE_SQUARE  = 3'd3;
  localparam logic [2:0] MODE_SWSTB   = 3'd4;
  localparam logic [2:0] MODE_HWSTB   = 3'd5;

  typedef enum logic [1:0] {SEL_FULL, SEL_HI, SEL_LO} loadSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    loadSel_e sel;
    logic     dec;
  } dpStrobe_t;

  // codes 6 and 7 alias the periodic modes
  function automatic logic [2:0] foldMode(logic [2:0] m);
    return (m[2:1] == 2'b11) ? {1'b0, m[1:0]} : m;
  endfunction

endpackage

// File: rtl/pit_chan_dp.sv
module pit_chan_dp
  import pit_chan_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dpStrobe_t             str,
  input  logic                  bcd,
  input  logic                  cntWr,
  input  logic [4*DIGITS-1:0]   cntVal,
  input  logic                  latchCmd,
  input  logic                  rdDone,
  output logic [4*DIGITS-1:0]   curCount,
  output logic                  atOne,
  output logic                  atTwo,
  output logic [4*DIGITS-1:0]   rdData,
  output logic                  rdHeld
);

  localparam int W = 4 * DIGITS;
  typedef logic [W-1:0] word_t;

  function automatic word_t stepDown(word_t v, logic dec10);
    word_t r;
    logic  borrow;
    r = v;
    borrow = 1'b1;
    if (!dec10) return v - word_t'(1);
    for (int i = 0; i < DIGITS; i++) begin
      if (borrow) begin
        if (v[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
        else begin
          r[4*i +: 4] = v[4*i +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic word_t stepUp(word_t v, logic dec10);
    word_t r;
    logic  carry;
    r = v;
    carry = 1'b1;
    if (!dec10) return v + word_t'(1);
    for (int i = 0; i < DIGITS; i++) begin
      if (carry) begin
        if (v[4*i +: 4] == 4'd9) r[4*i +: 4] = 4'd0;
        else begin
          r[4*i +: 4] = v[4*i +: 4] + 4'd1;
          carry = 1'b0;
        end
      end
    end
    return r;
  endfunction

  // floor(v/2); a zero count stands for the full range
  function automatic word_t halve(word_t v, logic dec10);
    word_t      r;
    logic       carry;
    logic [4:0] t;
    r = '0;
    carry = 1'b0;
    if (v == '0) begin
      if (dec10) r[W-4 +: 4] = 4'd5;
      else       r[W-1] = 1'b1;
      return r;
    end
    if (!dec10) return v >> 1;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      t = {1'b0, v[4*i +: 4]} + (carry ? 5'd10 : 5'd0);
      r[4*i +: 4] = t[4:1];
      carry = v[4*i];
    end
    return r;
  endfunction

  function automatic logic validDigits(word_t v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  word_t initReg, countReg, snapReg, loHalf, hiHalf;
  logic  heldQ;

  assign loHalf = halve(initReg, bcd);
  assign hiHalf = initReg[0] ? stepUp(loHalf, bcd) : loHalf;

  always_ff @(posedge clk) begin
    if (rst) begin
      initReg  <= '0;
      countReg <= '0;
    end else begin
      if (cntWr) initReg <= cntVal;
      if (str.load) begin
        unique case (str.sel)
          SEL_HI:  countReg <= hiHalf;
          SEL_LO:  countReg <= loHalf;
          default: countReg <= initReg;
        endcase
      end else if (str.dec) begin
        countReg <= stepDown(countReg, bcd);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      heldQ   <= 1'b0;
      snapReg <= '0;
    end else if (rdDone) begin
      heldQ <= 1'b0;
    end else if (latchCmd && !heldQ) begin
      heldQ   <= 1'b1;
      snapReg <= countReg;
    end
  end

  assign curCount = countReg;
  assign atOne    = (countReg == word_t'(1));
  assign atTwo    = (countReg == word_t'(2));
  assign rdData   = heldQ ? snapReg : countReg;
  assign rdHeld   = heldQ;

  AST_SNAPSHOT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (rdHeld && !rdDone) |=> $stable(rdData)); // R12

  AST_DECIMAL_STEP: assert property (@(posedge clk) disable iff (rst)
    (bcd && str.dec && !str.load && validDigits(countReg)) |=> validDigits(countReg)); // R11

endmodule

// File: rtl/pit_chan_ctl.sv
module pit_chan_ctl
  import pit_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgWr,
  input  logic [2:0] cfgMode,
  input  logic       cfgBcd,
  input  logic       cntWr,
  input  logic       gate,
  input  logic       atOne,
  input  logic       atTwo,
  output dpStrobe_t  str,
  output logic       bcd,
  output logic [2:0] mode,
  output logic       out
);

  logic [2:0] modeQ, modeN;
  logic bcdQ, bcdN, armedQ, armedN, pendQ, pendN, runQ, runN, gateQ, outQ, outN;
  logic gateRise, trigMode, periodic, startNow;

  assign gateRise = gate && !gateQ;
  assign trigMode = (modeQ == MODE_ONESHOT) || (modeQ == MODE_HWSTB);
  assign periodic = (modeQ == MODE_RATE) || (modeQ == MODE_SQUARE);
  assign startNow = pendQ || (armedQ && gateRise && (trigMode || periodic));

  always_comb begin
    str    = '{load: 1'b0, sel: SEL_FULL, dec: 1'b0};
    modeN  = modeQ;
    bcdN   = bcdQ;
    armedN = armedQ;
    pendN  = pendQ;
    runN   = runQ;
    outN   = outQ;
    if (cfgWr) begin
      modeN  = foldMode(cfgMode);
      bcdN   = cfgBcd;
      armedN = 1'b0;
      pendN  = 1'b0;
      runN   = 1'b0;
      outN   = (foldMode(cfgMode) != MODE_TC);
    end else begin
      if (startNow) begin
        str.load = 1'b1;
        str.sel  = (modeQ == MODE_SQUARE) ? SEL_HI : SEL_FULL;
        runN     = 1'b1;
        pendN    = 1'b0;
        if (modeQ == MODE_ONESHOT) outN = 1'b0;
        else if (modeQ != MODE_TC) outN = 1'b1;
      end else if (runQ && (trigMode || gate)) begin
        str.dec = 1'b1;
        unique case (modeQ)
          MODE_TC, MODE_ONESHOT: if (atOne) begin
            outN = 1'b1;
            runN = 1'b0;
          end
          MODE_RATE: begin
            outN = !(atTwo);
            if (atOne) begin
              str.dec  = 1'b0;
              str.load = 1'b1;
            end
          end
          MODE_SQUARE: if (atOne) begin
            str.dec  = 1'b0;
            str.load = 1'b1;
            str.sel  = outQ ? SEL_LO : SEL_HI;
            outN     = !outQ;
          end
          default: begin
            outN = !atOne;
            if (atOne) runN = 1'b0;
          end
        endcase
      end else if (periodic || modeQ == MODE_SWSTB || modeQ == MODE_HWSTB) begin
        outN = 1'b1;
      end
      if (cntWr) begin
        armedN = 1'b1;
        if (!trigMode) pendN = 1'b1;
        if (modeQ == MODE_TC) outN = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ  <= MODE_TC;
      bcdQ   <= 1'b0;
      armedQ <= 1'b0;
      pendQ  <= 1'b0;
      runQ   <= 1'b0;
      gateQ  <= 1'b0;
      outQ   <= 1'b1;
    end else begin
      modeQ  <= modeN;
      bcdQ   <= bcdN;
      armedQ <= armedN;
      pendQ  <= pendN;
      runQ   <= runN;
      gateQ  <= gate;
      outQ   <= outN;
    end
  end

  assign bcd  = bcdQ;
  assign mode = modeQ;
  assign out  = outQ;

  AST_RATE_LOW_ONE: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_RATE && !outQ && !cfgWr) |=> outQ); // R7

  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
    ((modeQ == MODE_SWSTB || modeQ == MODE_HWSTB) && !outQ && !cfgWr) |=> outQ); // R9

  AST_TC_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_TC && outQ && !cfgWr && !cntWr) |=> outQ); // R4

endmodule

// File: rtl/pit_chan.sv
module pit_chan
  import pit_chan_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfgWr,
  input  logic [2:0]          cfgMode,
  input  logic                cfgBcd,
  input  logic                cntWr,
  input  logic [4*DIGITS-1:0] cntVal,
  input  logic                gate,
  input  logic                latchCmd,
  input  logic                rdDone,
  output logic                out,
  output logic [4*DIGITS-1:0] rdData,
  output logic                rdHeld
);

  localparam int W = 4 * DIGITS;

  dpStrobe_t    str;
  logic         bcd, atOne, atTwo;
  logic [2:0]   mode;
  logic [W-1:0] countNow;

  pit_chan_ctl i_ctl (
    .clk(clk), .rst(rst), .cfgWr(cfgWr), .cfgMode(cfgMode), .cfgBcd(cfgBcd),
    .cntWr(cntWr), .gate(gate), .atOne(atOne), .atTwo(atTwo),
    .str(str), .bcd(bcd), .mode(mode), .out(out)
  );

  pit_chan_dp #(.DIGITS(DIGITS)) i_dp (
    .clk(clk), .rst(rst), .str(str), .bcd(bcd), .cntWr(cntWr), .cntVal(cntVal),
    .latchCmd(latchCmd), .rdDone(rdDone), .curCount(countNow),
    .atOne(atOne), .atTwo(atTwo), .rdData(rdData), .rdHeld(rdHeld)
  );

  AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_TC || mode == MODE_SWSTB) && !gate && !str.load) |=> $stable(countNow)); // R5

endmodule

// File: tb/test_pit_chan.sv
module test_pit_chan;

  logic        clk = 1'b0;
  logic        rst, cfgWr, cfgBcd, cntWr, gate, latchCmd, rdDone;
  logic [2:0]  cfgMode;
  logic [15:0] cntVal;
  logic        out, rdHeld;
  logic [15:0] rdData;
  int          total = 0;
  int          bad = 0;

  always #5 clk = ~clk;

  pit_chan i_pit_chan (
    .clk(clk), .rst(rst), .cfgWr(cfgWr), .cfgMode(cfgMode), .cfgBcd(cfgBcd),
    .cntWr(cntWr), .cntVal(cntVal), .gate(gate), .latchCmd(latchCmd),
    .rdDone(rdDone), .out(out), .rdData(rdData), .rdHeld(rdHeld)
  );

  // {mode, bcd, count, expected high cycles, expected low cycles}
  localparam logic [31:0] VEC [8] = '{
    {3'd2, 1'b0, 16'd5,     6'd4, 6'd1},
    {3'd2, 1'b0, 16'd2,     6'd1, 6'd1},
    {3'd3, 1'b0, 16'd6,     6'd3, 6'd3},
    {3'd3, 1'b0, 16'd7,     6'd4, 6'd3},
    {3'd3, 1'b1, 16'h0011,  6'd6, 6'd5},
    {3'd2, 1'b1, 16'h0010,  6'd9, 6'd1},
    {3'd6, 1'b0, 16'd3,     6'd2, 6'd1},
    {3'd7, 1'b0, 16'd9,     6'd5, 6'd4}
  };

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic writeCfg(logic [2:0] m, logic b);
    cfgWr = 1'b1; cfgMode = m; cfgBcd = b;
    step(1);
    cfgWr = 1'b0;
  endtask

  task automatic writeCnt(logic [15:0] v);
    cntWr = 1'b1; cntVal = v;
    step(1);
    cntWr = 1'b0;
  endtask

  task automatic measure(output int hi, output int lo);
    do step(1); while (out !== 1'b0);
    lo = 0;
    while (out === 1'b0) begin lo++; step(1); end
    hi = 0;
    while (out === 1'b1) begin hi++; step(1); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired (all requirements)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi, lo;
    rst = 1'b1; cfgWr = 0; cfgMode = 0; cfgBcd = 0; cntWr = 0; cntVal = 0;
    gate = 0; latchCmd = 0; rdDone = 0;
    step(3);
    chk("R1 out in reset", out, 1);
    rst = 1'b0;
    step(1);
    chk("R1 out", out, 1);
    chk("R1 rdData", rdData, 0);
    chk("R1 rdHeld", rdHeld, 0);

    // R2: one-shot without a count ignores gate
    writeCfg(3'd1, 1'b0);
    gate = 1; step(3);
    chk("R2 oneshot unarmed out", out, 1);
    chk("R2 oneshot unarmed count", rdData, 0);
    writeCfg(3'd0, 1'b0);
    step(5);
    chk("R2 mode0 no count", rdData, 0);

    // periodic modes from the vector table (R7, R8, R13)
    gate = 1;
    foreach (VEC[i]) begin
      writeCfg(VEC[i][31:29], VEC[i][28]);
      writeCnt(VEC[i][27:12]);
      step(2);
      measure(hi, lo);
      chk(VEC[i][31:30] == 2'b11 ? "R13 alias high" :
          (VEC[i][29] ? "R8 square high" : "R7 rate high"), hi, VEC[i][11:6]);
      chk(VEC[i][31:30] == 2'b11 ? "R13 alias low" :
          (VEC[i][29] ? "R8 square low" : "R7 rate low"), lo, VEC[i][5:0]);
    end

    // R4: mode 0, N=5
    writeCfg(3'd0, 1'b0);
    writeCnt(16'd5);
    chk("R4 out low after write", out, 0);
    step(5);
    chk("R4 out still low at N", out, 0);
    step(1);
    chk("R4 out high at N+1", out, 1);
    step(5);
    chk("R4 out stays high", out, 1);
    chk("R4 count holds at 0", rdData, 0);

    // R5: gate freeze in mode 0
    writeCnt(16'd10);
    step(3);
    gate = 0;
    step(5);
    chk("R5 frozen count", rdData, 8);
    gate = 1;
    step(1);
    chk("R5 resumed count", rdData, 7);

    // R11: decimal step
    writeCfg(3'd0, 1'b1);
    writeCnt(16'h0100);
    step(2);
    chk("R11 0100 to 0099", rdData, 16'h0099);
    step(1);
    chk("R11 next digit", rdData, 16'h0098);

    // R3: zero count in decimal = 10000
    writeCnt(16'h0000);
    step(10000);
    chk("R3 low before 10001", out, 0);
    step(1);
    chk("R3 high at 10001", out, 1);

    // R6: one-shot
    gate = 0;
    writeCfg(3'd1, 1'b0);
    writeCnt(16'd4);
    step(2);
    chk("R6 no trigger yet", out, 1);
    gate = 1; step(1);
    chk("R6 low after trigger", out, 0);
    writeCnt(16'd8);
    step(2);
    chk("R6 pulse keeps old count", out, 0);
    step(1);
    chk("R6 pulse ends at old N", out, 1);
    gate = 0; step(1);
    gate = 1; step(1);
    chk("R6 new trigger low", out, 0);
    step(7);
    chk("R6 new count still low", out, 0);
    step(1);
    chk("R6 new count ends", out, 1);
    gate = 0; step(1);
    gate = 1; step(3);
    gate = 0; step(1);
    gate = 1; step(1);
    step(7);
    chk("R6 retrigger extends pulse", out, 0);
    step(1);
    chk("R6 retrigger ends", out, 1);

    // R7: gate in rate mode
    writeCfg(3'd2, 1'b0);
    writeCnt(16'd5);
    step(7);
    gate = 0;
    step(1);
    hi = 0;
    for (int k = 0; k < 8; k++) begin
      if (out !== 1'b1) hi++;
      step(1);
    end
    chk("R7 gate low forces high", hi, 0);
    gate = 1;
    step(1);
    step(3);
    chk("R7 reload high", out, 1);
    step(1);
    chk("R7 low at count 1", out, 0);
    step(1);
    chk("R7 back high", out, 1);

    // R9: software strobe
    writeCfg(3'd4, 1'b0);
    writeCnt(16'd3);
    step(3);
    chk("R9 high before strobe", out, 1);
    step(1);
    chk("R9 strobe low", out, 0);
    step(1);
    chk("R9 strobe one cycle", out, 1);
    step(20);
    chk("R9 single strobe", out, 1);

    // R10: hardware strobe
    gate = 0;
    writeCfg(3'd5, 1'b0);
    writeCnt(16'd3);
    step(5);
    chk("R10 waits for gate", out, 1);
    gate = 1; step(1);
    step(2);
    chk("R10 high before TC", out, 1);
    step(1);
    chk("R10 strobe low", out, 0);
    step(1);
    chk("R10 strobe one cycle", out, 1);
    gate = 0; step(1);
    gate = 1; step(1);
    gate = 0; step(1);
    gate = 1; step(1);
    step(1);
    chk("R10 retrigger delays strobe", out, 1);
    step(2);
    chk("R10 retriggered strobe", out, 0);

    // R12: latch
    writeCfg(3'd0, 1'b0);
    writeCnt(16'd100);
    step(10);
    chk("R12 live count", rdData, 91);
    latchCmd = 1; step(1); latchCmd = 0;
    chk("R12 held flag", rdHeld, 1);
    chk("R12 snapshot", rdData, 91);
    step(5);
    chk("R12 snapshot stable", rdData, 91);
    rdDone = 1; step(1); rdDone = 0;
    chk("R12 released", rdHeld, 0);
    chk("R12 counting continued", rdData, 84);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule